// File: doc/BRIEF.md
# Hall Position Latch with Tachometer Blanking

This block takes the three Hall-effect rotor position signals of a brushless motor, brings them into the clock domain, and holds the accepted rotor code in a set of position latches. When the synchronized code differs from the held code, the block loads all three bits at once. On the same clock edge it starts a one-shot tachometer pulse of programmable width. The average value of the tachometer pulse train tracks motor speed. The same pulse also serves as a blanking window: while it is high, the position latches are frozen. Chatter that follows a commutation edge therefore cannot reach the commutation decoder, and the pulse width sets the highest commutation rate the block accepts.

A direction controller can start a pulse through a separate trigger input, so a direction change produces a tachometer pulse even when the rotor is not turning. A brake input turns the tachometer off. While brake is high, no pulse starts and any running pulse is cut off. With no pulse to blank them, the latches follow the synchronized Hall code freely. All pins are plain level signals sampled on the rising clock edge. The Hall pins are asynchronous. The trigger, brake and width inputs are synchronous to the clock. Because no data stream passes through the block, there is no valid/ready handshake and no back-pressure.

Top module: `hall_tach_blanker`

## Requirements
- R1: While rst_n is low, h_lat reads 3'b000 and tach_out reads 0.
- R2: Each Hall bit passes through a two-flop synchronizer. A change applied to h just after a rising edge reaches h_lat on the third following rising edge, provided the latches are not blanked.
- R3: When the synchronized Hall code differs from h_lat and the latches are not blanked, all three bits of h_lat load the synchronized code on that edge. Bit i of h_lat follows bit i of h.
- R4: A latch load while tach_out is low, brake is low and pulse_len is non-zero raises tach_out on the same edge. tach_out then stays high for exactly pulse_len clock cycles.
- R5: While tach_out is high and brake is low, h_lat does not change, whatever happens on h.
- R6: A Hall change that is still present when a pulse ends is latched on the first edge at which tach_out was low before the edge. That edge also starts a new pulse.
- R7: A one-cycle high on ext_trig while tach_out is low, brake is low and pulse_len is non-zero starts a pulse of pulse_len cycles. h_lat is left unchanged.
- R8: A trigger from ext_trig or from a Hall change that arrives while a pulse is running is ignored. The pulse does not lengthen and no second pulse follows it.
- R9: With pulse_len equal to 0, no pulse starts and the latches are never blanked. h_lat follows every synchronized change.
- R10: While brake is high, tach_out is low from the next edge on, ext_trig has no effect, and h_lat follows synchronized changes without blanking.
- R11: The width is taken from pulse_len at the edge that starts the pulse. Changing pulse_len during a pulse does not alter that pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| h | input | 3 | Asynchronous Hall position inputs |
| ext_trig | input | 1 | Synchronous one-shot trigger from the direction controller |
| brake | input | 1 | High disables the tachometer and the blanking |
| pulse_len | input | 16 | Tachometer pulse width in clock cycles; 0 disables pulses |
| h_lat | output | 3 | Latched rotor position code |
| tach_out | output | 1 | Tachometer pulse, also the blanking window |

## Verification
The bench targets the edge at which a pulse ends. A design that released the latches one cycle late would delay the pending commutation. A design that released them one cycle early would make every pulse one cycle short, and the cycle-by-cycle comparison catches both. It sends extra triggers into a running pulse and changes pulse_len mid-pulse. A one-shot that re-armed or re-read the width would show a longer pulse. It also drives a zero width and raises brake in the middle of a pulse. A design that treated zero as a maximal count would show a pulse where none is allowed. One that left blanking tied to a killed pulse would keep the latches frozen while brake is high.

// File: rtl/hall_tach_pkg.sv
package hall_tach_pkg;
  typedef enum logic {
    OS_IDLE = 1'b0,
    OS_RUN  = 1'b1
  } os_state_e;
endpackage

// File: rtl/hall_sync.sv
module hall_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [STAGES-1:0][W-1:0] stg;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (!rst_n) stg <= '0;
        else        stg <= din;
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (!rst_n) stg <= '0;
        else        stg <= {stg[STAGES-2:0], din};
      end
    end
  endgenerate

  assign dout = stg[STAGES-1];
endmodule

// File: rtl/position_latch.sv
module position_latch #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] code_in,
  input  logic         allow,
  output logic [W-1:0] code_q,
  output logic         load
);
  logic differs;

  assign differs = (code_in != code_q);
  assign load    = differs & allow;

  always_ff @(posedge clk) begin
    if (!rst_n)    code_q <= '0;
    else if (load) code_q <= code_in;
  end
endmodule

// File: rtl/tach_oneshot.sv
module tach_oneshot
  import hall_tach_pkg::*;
#(
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trig,
  input  logic             kill,
  input  logic [LEN_W-1:0] len,
  output logic             busy
);
  localparam logic [LEN_W-1:0] ONE = LEN_W'(1);

  os_state_e        state;
  logic [LEN_W-1:0] remain;
  logic             start;

  assign busy  = (state == OS_RUN);
  assign start = trig & ~busy & ~kill & (len != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= OS_IDLE;
      remain <= '0;
    end else if (kill) begin
      state  <= OS_IDLE;
      remain <= '0;
    end else if (start) begin
      state  <= OS_RUN;
      remain <= len;
    end else if (busy) begin
      if (remain == ONE) begin
        state  <= OS_IDLE;
        remain <= '0;
      end else begin
        remain <= remain - ONE;
      end
    end
  end
endmodule

// File: rtl/hall_tach_blanker.sv
module hall_tach_blanker #(
  parameter int NUM_SENSORS = 3,
  parameter int SYNC_STAGES = 2,
  parameter int LEN_W       = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NUM_SENSORS-1:0] h,
  input  logic                   ext_trig,
  input  logic                   brake,
  input  logic [LEN_W-1:0]       pulse_len,
  output logic [NUM_SENSORS-1:0] h_lat,
  output logic                   tach_out
);
  logic [NUM_SENSORS-1:0] h_sync;
  logic                   busy;
  logic                   load;
  logic                   allow;

  hall_sync #(.W(NUM_SENSORS), .STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (h),
    .dout (h_sync)
  );

  assign allow = ~busy | brake;

  position_latch #(.W(NUM_SENSORS)) u_latch (
    .clk    (clk),
    .rst_n  (rst_n),
    .code_in(h_sync),
    .allow  (allow),
    .code_q (h_lat),
    .load   (load)
  );

  tach_oneshot #(.LEN_W(LEN_W)) u_tach (
    .clk  (clk),
    .rst_n(rst_n),
    .trig (load | ext_trig),
    .kill (brake),
    .len  (pulse_len),
    .busy (busy)
  );

  assign tach_out = busy;
endmodule

// File: rtl/hall_tach_blanker_chk.sv
module hall_tach_blanker_chk #(
  parameter int NUM_SENSORS = 3,
  parameter int LEN_W       = 16
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   ext_trig,
  input logic                   brake,
  input logic [LEN_W-1:0]       pulse_len,
  input logic [NUM_SENSORS-1:0] h_lat,
  input logic                   tach_out
);
  assert_blank_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (tach_out && !brake) |=> $stable(h_lat));

  assert_brake_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    brake |=> !tach_out);

  assert_trig_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_trig && !tach_out && !brake && pulse_len != '0) |=> tach_out);

  assert_zero_len_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!tach_out && pulse_len == '0) |=> !tach_out);

  assert_load_fires_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!tach_out && !brake && pulse_len != '0) |=> ($stable(h_lat) || tach_out));
endmodule

bind hall_tach_blanker hall_tach_blanker_chk #(
  .NUM_SENSORS(NUM_SENSORS),
  .LEN_W      (LEN_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .ext_trig (ext_trig),
  .brake    (brake),
  .pulse_len(pulse_len),
  .h_lat    (h_lat),
  .tach_out (tach_out)
);

// File: tb/hall_tach_blanker_test.sv
`timescale 1ns/1ps
module hall_tach_blanker_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  h = 3'b000;
  logic        ext_trig = 1'b0;
  logic        brake = 1'b0;
  logic [15:0] pulse_len = 16'd5;
  logic [2:0]  h_lat;
  logic        tach_out;

  int    total = 0;
  int    bad = 0;
  bit    done = 0;
  string tag = "R1";

  // reference model state
  logic [2:0] m_s1 = 0, m_s2 = 0, m_lat = 0;
  int         m_cnt = 0;

  always #4 clk = ~clk;

  hall_tach_blanker uut (
    .clk(clk), .rst_n(rst_n), .h(h), .ext_trig(ext_trig),
    .brake(brake), .pulse_len(pulse_len), .h_lat(h_lat), .tach_out(tach_out)
  );

  always @(posedge clk) begin
    bit active, ld;
    logic [2:0] n_lat;
    int n_cnt;
    if (!rst_n) begin
      m_s1 = 0; m_s2 = 0; m_lat = 0; m_cnt = 0;
    end else begin
      active = (m_cnt != 0);
      n_lat  = m_lat;
      n_cnt  = active ? m_cnt - 1 : 0;
      if (brake) n_cnt = 0;
      ld = (m_s2 != m_lat) && (!active || brake);
      if (ld) n_lat = m_s2;
      if ((ld || ext_trig) && !active && !brake && pulse_len != 0) n_cnt = pulse_len;
      m_s2 = m_s1; m_s1 = h; m_lat = n_lat; m_cnt = n_cnt;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // cycle compare against the model
  always @(negedge clk) begin
    if (!done) begin
      chk(h_lat === m_lat, tag, h_lat, m_lat);
      chk(tach_out === (m_cnt != 0), tag, tach_out, m_cnt != 0);
    end
  end

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #1_000_000;
    bad++; total++;
    $display("FAIL watchdog actual=1 expected=0");
    finish_run();
  end

  initial begin
    int wid;
    int idx;
    logic [2:0] seq [6];
    seq[0] = 3'b001; seq[1] = 3'b011; seq[2] = 3'b010;
    seq[3] = 3'b110; seq[4] = 3'b100; seq[5] = 3'b101;

    // R1 reset state
    tag = "R1";
    cyc(3);
    chk(h_lat == 3'b000, "R1", h_lat, 0);
    chk(tach_out == 1'b0, "R1", tach_out, 0);
    rst_n = 1'b1;
    cyc(3);

    // R2 latency, R3 load, R4 width
    tag = "R2";
    h = 3'b001;
    cyc(2);
    chk(h_lat == 3'b000, "R2", h_lat, 0);
    cyc(1);
    chk(h_lat == 3'b001, "R3", h_lat, 1);
    chk(tach_out == 1'b1, "R4", tach_out, 1);
    wid = 0;
    while (tach_out && wid < 100) begin wid++; cyc(1); end
    chk(wid == 5, "R4", wid, 5);
    cyc(4);

    // R5 blanking, R6 pending change taken after pulse
    tag = "R5";
    h = 3'b011;
    cyc(3);
    h = 3'b010;
    cyc(2);
    chk(h_lat == 3'b011, "R5", h_lat, 3);
    tag = "R6";
    cyc(4);
    chk(h_lat == 3'b010, "R6", h_lat, 2);
    chk(tach_out == 1'b1, "R6", tach_out, 1);
    cyc(8);

    // R7 external trigger, R8 ignored retrigger, R11 width held
    tag = "R7";
    ext_trig = 1'b1; cyc(1); ext_trig = 1'b0;
    chk(tach_out == 1'b1, "R7", tach_out, 1);
    chk(h_lat == 3'b010, "R7", h_lat, 2);
    tag = "R8";
    ext_trig = 1'b1; pulse_len = 16'd40; cyc(1); ext_trig = 1'b0;
    wid = 2;
    while (tach_out && wid < 100) begin wid++; cyc(1); end
    chk(wid == 6, "R8", wid, 6);
    tag = "R11";
    chk(wid - 1 == 5, "R11", wid - 1, 5);
    pulse_len = 16'd5;
    cyc(3);

    // R9 zero width
    tag = "R9";
    pulse_len = 16'd0;
    for (int i = 0; i < 6; i++) begin h = seq[i]; cyc(1); end
    ext_trig = 1'b1; cyc(1); ext_trig = 1'b0;
    cyc(3);
    chk(h_lat == 3'b101, "R9", h_lat, 5);
    chk(tach_out == 1'b0, "R9", tach_out, 0);

    // R10 brake mid-pulse
    tag = "R10";
    pulse_len = 16'd20;
    h = 3'b001; cyc(4);
    chk(tach_out == 1'b1, "R10", tach_out, 1);
    brake = 1'b1; cyc(1);
    chk(tach_out == 1'b0, "R10", tach_out, 0);
    h = 3'b011; ext_trig = 1'b1; cyc(1); ext_trig = 1'b0;
    cyc(3);
    chk(h_lat == 3'b011, "R10", h_lat, 3);
    chk(tach_out == 1'b0, "R10", tach_out, 0);
    brake = 1'b0;
    cyc(25);

    // R3 rotating sequence with random dwell and disturbances
    tag = "R3";
    idx = 1;
    for (int n = 0; n < 1500; n++) begin
      idx = ($urandom_range(0, 3) == 0) ? (idx + 5) % 6 : (idx + 1) % 6;
      h = seq[idx];
      pulse_len = 16'($urandom_range(0, 7));
      brake = ($urandom_range(0, 15) == 0);
      ext_trig = ($urandom_range(0, 9) == 0);
      cyc(1);
      ext_trig = 1'b0;
      cyc($urandom_range(0, 10));
    end
    brake = 1'b0;
    cyc(20);
    finish_run();
  end
endmodule